// File: doc/BRIEF.md
# Two-Channel System Timer

This block is a memory-mapped system timer holding two counting channels that share one reference tick input. Each channel has its own power-of-four prescaler, so it advances once per 1, 4, 16 or 64 reference ticks. Channel 1 is an event timer. A software-loaded compare value is matched against its 32-bit up-counter, and a match sets a sticky flag. That flag drives the interrupt output unless a mask bit blocks it. Channel 2 is a free-running counter that software samples as a time base.

Software reaches the block through a plain 32-bit register bus made of an address, a write strobe, a read strobe, write data and combinational read data. Channels are switched on and off through a pair of write-one-to-set and write-one-to-clear registers. Each counter can be zeroed through its own bit in a clear register. The address map is fixed: 0x00 prescale control, 0x08 counter clear, 0x0C flag, 0x10 mask, 0x14 compare value, 0x18 channel 1 count, 0x20 channel 2 count (low word), 0x24 channel 2 high-word buffer, 0x34 enable set, 0x38 enable clear. Any other address reads as 0.

Top module: `systmr_top`

## Requirements
- R1: After reset both enables are 0, the flag is 0, the mask is 1, and the prescale codes, both counters and the compare value are 0.
- R2: Register 0x00 holds the channel 1 prescale code in bits [1:0] and the channel 2 code in bits [3:2], and reads back what was written. Code c makes the channel advance once every 4^c reference ticks (0: 1, 1: 4, 2: 16, 3: 64). When a code changes, that channel's tick divider restarts from zero.
- R3: Writing 1 to bit 0 or bit 1 of 0x34 enables channel 1 or channel 2. Writing 1 to the same bit of 0x38 disables that channel. Zero bits in either register change nothing. Reading 0x34 returns the enables in bits [1:0].
- R4: Writing 1 to bit 0 or bit 1 of 0x08 zeroes the channel 1 or channel 2 counter, and the clear wins over a same-cycle increment. Zero bits leave the counters unchanged.
- R5: An enabled channel's counter increments once per prescaled tick. A disabled channel holds its count. Channel 1's count reads at 0x18.
- R6: The compare value is written and read at 0x14. When an increment brings the channel 1 count equal to the compare value, the flag (0x0C bit 0) reads 1 from the next cycle.
- R7: Writing 0x0C with bit 0 equal to 0 clears the flag, and writing it with bit 0 equal to 1 has no effect. A compare match in the same cycle as a clearing write leaves the flag set.
- R8: Register 0x10 bit 0 is the interrupt mask. The interrupt output is the flag AND NOT the mask.
- R9: Reading 0x20 returns the low 32 bits of channel 2 and captures its high bits into the buffer at 0x24, which reads as 0 when channel 2 is 32 bits wide. Both counters wrap modulo 2^width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used for the high-word capture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Compare interrupt, flag gated by mask |

## Verification
The prescaler restart on a code change is the hardest behaviour to expose from the ports. A divider that keeps its old phase yields counts that look plausible unless the phase sits past the new terminal value when the code is switched. To reach that point, the stimulus runs channel 2 at divide-by-16 for ten reference ticks. It then switches to divide-by-4 and expects exactly one increment after four more ticks. Wrap of the 32-bit counters and compare values near 0xFFFFFFFF cannot be reached in a short run without a preload path, so the wrap is guarded by an assertion in the counter.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
   localparam int NUM_CH = 2;
   localparam logic [7:0] OFF_CLKCTL = 8'h00;
   localparam logic [7:0] OFF_CLR    = 8'h08;
   localparam logic [7:0] OFF_FLAG   = 8'h0C;
   localparam logic [7:0] OFF_MASK   = 8'h10;
   localparam logic [7:0] OFF_CMP    = 8'h14;
   localparam logic [7:0] OFF_CNT1   = 8'h18;
   localparam logic [7:0] OFF_CNT2L  = 8'h20;
   localparam logic [7:0] OFF_CNT2H  = 8'h24;
   localparam logic [7:0] OFF_ENSET  = 8'h34;
   localparam logic [7:0] OFF_ENCLR  = 8'h38;
endpackage

// File: rtl/systmr_prescaler.sv
module systmr_prescaler #(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int DIV_W = 2 * ((1 << CODE_W) - 1);

   if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code_w
      $error("systmr_prescaler: CODE_W must be 1..3");
   end

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] last;
   logic [DIV_W:0]   span;
   logic [CODE_W-1:0] code_q;
   logic             restart;

   // span = 4^code, last = span - 1 (wraps to all ones for the top code)
   assign span    = {{DIV_W{1'b0}}, 1'b1} << {code, 1'b0};
   assign last    = DIV_W'(span - 1'b1);
   assign restart = (code != code_q);
   assign tick    = ref_tick && !restart && (phase_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         code_q  <= '0;
      end else begin
         code_q <= code;
         if (restart)
            phase_q <= '0;
         else if (ref_tick)
            phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
      end
   end

   AST_NO_TICK_ON_CODE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code) |-> !tick); // R2
endmodule

// File: rtl/systmr_counter.sv
module systmr_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         step
);
   if (W < 2) begin : g_bad_w
      $error("systmr_counter: W must be at least 2");
   end

   assign step = en && tick && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt)); // R5
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && en && tick) |=> (cnt == '0)); // R4
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !clr && (cnt == '1)) |=> (cnt == '0)); // R9
endmodule

// File: rtl/systmr_top.sv
module systmr_top #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CH2_W  = 32,
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import systmr_pkg::*;

   localparam int CTL_W = NUM_CH * CODE_W;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("systmr_top: ADDR_W must reach offset 0x38");
   end
   if (CH2_W < DATA_W || CH2_W > 2 * DATA_W) begin : g_bad_ch2
      $error("systmr_top: CH2_W must lie in DATA_W..2*DATA_W");
   end
   if (DATA_W < CTL_W) begin : g_bad_data
      $error("systmr_top: DATA_W too small for prescale fields");
   end

   logic wr_clkctl, wr_clr, wr_flag, wr_mask, wr_cmp, wr_enset, wr_enclr, rd_cnt2l;
   assign wr_clkctl = bus_wr && (bus_addr == ADDR_W'(OFF_CLKCTL));
   assign wr_clr    = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));
   assign wr_flag   = bus_wr && (bus_addr == ADDR_W'(OFF_FLAG));
   assign wr_mask   = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
   assign wr_cmp    = bus_wr && (bus_addr == ADDR_W'(OFF_CMP));
   assign wr_enset  = bus_wr && (bus_addr == ADDR_W'(OFF_ENSET));
   assign wr_enclr  = bus_wr && (bus_addr == ADDR_W'(OFF_ENCLR));
   assign rd_cnt2l  = bus_rd && (bus_addr == ADDR_W'(OFF_CNT2L));

   // R1: every register below resets to the documented idle state
   logic [CTL_W-1:0]  ctrl_q;
   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] clr_v;
   logic [NUM_CH-1:0] tick_v;
   logic [NUM_CH-1:0] step_v;
   logic              flag_q;
   logic              mask_q;
   logic [DATA_W-1:0] cmp_q;
   logic [DATA_W-1:0] hibuf_q;
   logic [DATA_W-1:0] cnt1;
   logic [CH2_W-1:0]  cnt2;
   logic              hit;

   assign clr_v = wr_clr ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      systmr_prescaler #(.CODE_W(CODE_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .ref_tick (ref_tick),
         .code     (ctrl_q[g*CODE_W +: CODE_W]),
         .tick     (tick_v[g])
      );
      if (g == 0) begin : g_event
         systmr_counter #(.W(DATA_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .en (en_q[g]), .clr (clr_v[g]),
            .tick (tick_v[g]), .cnt (cnt1), .step (step_v[g])
         );
      end else begin : g_free
         systmr_counter #(.W(CH2_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .en (en_q[g]), .clr (clr_v[g]),
            .tick (tick_v[g]), .cnt (cnt2), .step (step_v[g])
         );
      end
   end

   assign hit = step_v[0] && ((cnt1 + 1'b1) == cmp_q);
   assign irq = flag_q && !mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         en_q    <= '0;
         flag_q  <= 1'b0;
         mask_q  <= 1'b1;
         cmp_q   <= '0;
         hibuf_q <= '0;
      end else begin
         if (wr_clkctl) ctrl_q <= bus_wdata[CTL_W-1:0];
         if (wr_enset)
            en_q <= en_q | bus_wdata[NUM_CH-1:0];
         else if (wr_enclr)
            en_q <= en_q & ~bus_wdata[NUM_CH-1:0];
         if (hit)
            flag_q <= 1'b1;
         else if (wr_flag && !bus_wdata[0])
            flag_q <= 1'b0;
         if (wr_mask) mask_q <= bus_wdata[0];
         if (wr_cmp)  cmp_q  <= bus_wdata;
         if (rd_cnt2l) hibuf_q <= DATA_W'(cnt2 >> DATA_W);
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_CLKCTL): bus_rdata = DATA_W'(ctrl_q);
         ADDR_W'(OFF_FLAG):   bus_rdata = DATA_W'(flag_q);
         ADDR_W'(OFF_MASK):   bus_rdata = DATA_W'(mask_q);
         ADDR_W'(OFF_CMP):    bus_rdata = cmp_q;
         ADDR_W'(OFF_CNT1):   bus_rdata = cnt1;
         ADDR_W'(OFF_CNT2L):  bus_rdata = cnt2[DATA_W-1:0];
         ADDR_W'(OFF_CNT2H):  bus_rdata = hibuf_q;
         ADDR_W'(OFF_ENSET):  bus_rdata = DATA_W'(en_q);
         default:             bus_rdata = '0;
      endcase
   end

   AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enset && bus_wdata[1]) |=> en_q[1]); // R3
   AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enclr && bus_wdata[0]) |=> !en_q[0]); // R3
   AST_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt1) && (cnt1 == cmp_q) && $stable(cmp_q) && !$past(clr_v[0])) |-> flag_q); // R6
   AST_FLAG_ONE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[0] && flag_q) |=> flag_q); // R7
   AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq); // R8
endmodule

// File: tb/sim_systmr_top.sv
`timescale 1ns/1ps
module sim_systmr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   systmr_top u0 (
      .clk (clk), .rst_n (rst_n), .ref_tick (ref_tick),
      .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
   );

   // {req[80:73], wr[72], addr[71:64], wdata[63:32], expect[31:0]}
   localparam int NV = 22;
   localparam logic [80:0] VEC [NV] = '{
      {8'd1, 1'b0, 8'h00, 32'h0, 32'h0},   // R1 prescale codes
      {8'd1, 1'b0, 8'h10, 32'h0, 32'h1},   // R1 mask set
      {8'd1, 1'b0, 8'h0C, 32'h0, 32'h0},   // R1 flag clear
      {8'd1, 1'b0, 8'h14, 32'h0, 32'h0},   // R1 compare
      {8'd1, 1'b0, 8'h18, 32'h0, 32'h0},   // R1 ch1 count
      {8'd1, 1'b0, 8'h20, 32'h0, 32'h0},   // R1 ch2 count
      {8'd1, 1'b0, 8'h34, 32'h0, 32'h0},   // R1 enables
      {8'd2, 1'b1, 8'h00, 32'h9, 32'h0},   // R2 write codes
      {8'd2, 1'b0, 8'h00, 32'h0, 32'h9},
      {8'd6, 1'b1, 8'h14, 32'h4, 32'h0},   // R6 compare write
      {8'd6, 1'b0, 8'h14, 32'h0, 32'h4},
      {8'd3, 1'b1, 8'h34, 32'h3, 32'h0},   // R3 set both
      {8'd3, 1'b0, 8'h34, 32'h0, 32'h3},
      {8'd3, 1'b1, 8'h38, 32'h1, 32'h0},   // R3 clear ch1
      {8'd3, 1'b0, 8'h34, 32'h0, 32'h2},
      {8'd3, 1'b1, 8'h34, 32'h0, 32'h0},   // R3 zero set bits
      {8'd3, 1'b0, 8'h34, 32'h0, 32'h2},
      {8'd3, 1'b1, 8'h38, 32'h0, 32'h0},   // R3 zero clear bits
      {8'd3, 1'b0, 8'h34, 32'h0, 32'h2},
      {8'd8, 1'b1, 8'h10, 32'h0, 32'h0},   // R8 unmask
      {8'd8, 1'b0, 8'h10, 32'h0, 32'h0},
      {8'd9, 1'b0, 8'h24, 32'h0, 32'h0}    // R9 high buffer
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 check(tag, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic irq_is(input logic exp, input string tag);
      @(negedge clk);
      #1 check(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      irq_is(1'b0, "R1 irq after reset");
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72])
            wr(VEC[i][71:64], VEC[i][63:32]);
         else
            rd(VEC[i][71:64], VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][80:73], i));
      end
      // directed: compare event, mask is 0 from the table
      wr(8'h38, 32'h3);
      wr(8'h00, 32'h0);
      wr(8'h14, 32'h4);
      wr(8'h34, 32'h3);
      ticks(3);
      rd(8'h18, 32'd3, "R5 ch1 count after 3 ticks");
      rd(8'h0C, 32'd0, "R6 flag before match");
      ticks(1);
      rd(8'h0C, 32'd1, "R6 flag at match");
      irq_is(1'b1, "R8 irq unmasked");
      wr(8'h10, 32'h1);
      irq_is(1'b0, "R8 irq masked");
      wr(8'h10, 32'h0);
      irq_is(1'b1, "R8 irq unmasked again");
      wr(8'h0C, 32'h1);
      rd(8'h0C, 32'd1, "R7 writing one keeps flag");
      wr(8'h0C, 32'h0);
      rd(8'h0C, 32'd0, "R7 writing zero clears flag");
      irq_is(1'b0, "R7 irq drops with flag");
      ticks(2);
      rd(8'h0C, 32'd0, "R6 no flag past compare");
      wr(8'h38, 32'h1);
      ticks(5);
      rd(8'h18, 32'd6, "R5 disabled ch1 holds");
      rd(8'h20, 32'd11, "R5 ch2 keeps counting");
      wr(8'h08, 32'h1);
      rd(8'h18, 32'd0, "R4 ch1 cleared");
      rd(8'h20, 32'd11, "R4 ch2 untouched by ch1 clear");
      wr(8'h08, 32'h0);
      rd(8'h20, 32'd11, "R4 zero clear bits no effect");
      // prescale on channel 2
      wr(8'h00, 32'h4);
      wr(8'h08, 32'h2);
      ticks(8);
      rd(8'h20, 32'd2, "R2 divide by 4");
      wr(8'h00, 32'h8);
      wr(8'h08, 32'h2);
      ticks(32);
      rd(8'h20, 32'd2, "R2 divide by 16 two periods");
      ticks(15);
      rd(8'h20, 32'd2, "R2 divide by 16 one short");
      ticks(1);
      rd(8'h20, 32'd3, "R2 divide by 16 third step");
      ticks(10);
      wr(8'h00, 32'h4);
      ticks(4);
      rd(8'h20, 32'd4, "R2 divider restarts on code change");
      rd(8'h24, 32'd0, "R9 high buffer after capture");
      // prescaled compare on channel 1
      wr(8'h00, 32'h5);
      wr(8'h08, 32'h1);
      wr(8'h14, 32'h2);
      wr(8'h34, 32'h1);
      ticks(7);
      rd(8'h18, 32'd1, "R5 ch1 divide by 4");
      rd(8'h0C, 32'd0, "R6 no flag before prescaled match");
      ticks(1);
      rd(8'h0C, 32'd1, "R6 flag at prescaled match");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule